// File: doc/BRIEF.md
# Programmable Block-Size Chip-Select Decoder

This block turns ISA bus addresses into chip selects for up to five logical devices that share one expansion card. Each device holds an I/O window, given as a 16-bit base and a 3-bit size code covering 1 to 64 bytes. The first two devices also hold a memory window, given as a base and an inclusive upper limit at 256-byte granularity. A device active bit gates every select the device can produce. The AEN strobe from DMA cycles blocks all I/O decoding.

A global mode bit picks one of two layouts. In two-device mode, devices 0 and 1 decode both I/O and memory. In five-device mode, all five devices decode I/O and no memory select is produced. Two transceiver output enables follow I/O reads to a device picked by a 3-bit code. A device that is inactive but has range checking enabled answers reads inside its I/O window with a fixed byte, so that software can detect conflicts before activating it.

Configuration is written over a parallel bus: a write strobe, a device index, a field select and 16 data bits. The decode paths are combinational from the stored configuration and the bus inputs.

Top module: `pnp_cs_decoder`

## Requirements
- R1: After reset every stored field is zero, so the mode is two-device and every device is inactive. With the bus inputs low, `iocs_o`, `mcs_o`, `oen_o`, `rd_oe_o` and `rd_data_o` are all zero.
- R2: A size code k in the range 0..6 makes device I/O matching compare address bits 15 down to k with the base. A window therefore spans 2^k bytes. Codes 7 behave as code 6.
- R3: While `aen_i` is high, `iocs_o`, `oen_o` and `rd_oe_o` are all low, whatever the address and configuration.
- R4: A device whose active bit (control field bit 0) is clear asserts neither its I/O select, its memory select nor any output enable.
- R5: In two-device mode, `mcs_o[m]` for m in 0..1 is high exactly when device m is active and base <= `mem_addr_i[23:8]` <= upper limit, with both bounds inclusive.
- R6: In five-device mode `mcs_o` is always zero and devices 0..4 all decode I/O. In two-device mode `iocs_o[4:2]` are always zero.
- R7: An inactive device with range check enabled (control bit 1) answers a read in two-device or five-device layout. The read must have `ior_i` high, `aen_i` low and `io_addr_i` inside the device's window. The answer is `rd_oe_o` high with `rd_data_o` equal to 0x55 if control bit 2 is set, or 0xAA if it is clear. The lowest-index such device wins. Otherwise `rd_oe_o` and `rd_data_o` are zero.
- R8: `oen_o[0]` is high only while `ior_i` is high and the selected device's I/O select is high. In two-device mode, code 000 picks device 0, 001 picks device 1, 010 picks either, and other codes pick none.
- R9: In five-device mode, codes 000..100 on either OEN code field pick devices 0..4, and other codes pick none. `oen_o[1]` is low in two-device mode. The OEN codes sit in global field bits 3:1 and 6:4, and the mode bit is global bit 0.
- R10: Configuration fields are selected by field code: 0 is the I/O base, 1 is the size code in data bits 2:0, 2 is the memory base, 3 is the memory upper limit, 4 is control, and 5 is global. A write takes effect for decoding from the cycle after its strobe edge. Device-indexed writes with index 5 or above, and writes with field codes 6 or 7, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_dev_i | input | 3 | Device index for the write |
| cfg_field_i | input | 3 | Field select for the write |
| cfg_wdata_i | input | 16 | Write data |
| io_addr_i | input | 16 | ISA I/O address |
| mem_addr_i | input | 24 | ISA memory address |
| aen_i | input | 1 | DMA address enable, high blocks I/O decode |
| ior_i | input | 1 | I/O read strobe, active high |
| iocs_o | output | 5 | Per-device I/O chip selects |
| mcs_o | output | 2 | Memory chip selects for devices 0 and 1 |
| oen_o | output | 2 | Transceiver output enables |
| rd_oe_o | output | 1 | Range-check data drive enable |
| rd_data_o | output | 8 | Range-check response byte |

## Verification
A wrong stored base or size code shows as a select that misses, or answers, an address one byte beyond a window edge. Such a fault is visible in the same cycle the address is presented. A mode or active bit held wrongly shows as memory selects in five-device mode, or as selects from a dormant device, on the first access after the write. Random configuration writes interleave with addresses placed near programmed bases. Directed probes hit each window edge, so every stored field is observed at the ports within a few cycles of being written.

// File: rtl/pnp_cs_pkg.sv
package pnp_cs_pkg;
  typedef enum logic [2:0] {
    FLD_IO_BASE  = 3'd0,
    FLD_IO_SIZE  = 3'd1,
    FLD_MEM_BASE = 3'd2,
    FLD_MEM_TOP  = 3'd3,
    FLD_CTRL     = 3'd4,
    FLD_GLOBAL   = 3'd5
  } cfg_field_e;

  localparam int unsigned CODE_W       = 3;
  localparam int unsigned MAX_SIZE     = 6;
  localparam logic [7:0]  RC_BYTE_SET  = 8'h55;
  localparam logic [7:0]  RC_BYTE_CLR  = 8'hAA;
endpackage

// File: rtl/pnp_cfg_regs.sv
module pnp_cfg_regs
  import pnp_cs_pkg::*;
#(
  parameter int NUM_DEV = 5,
  parameter int NUM_MEM = 2,
  parameter int IO_AW   = 16,
  parameter int MEM_FW  = 16,
  parameter int CFG_W   = 16,
  parameter int DEV_W   = 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [DEV_W-1:0]                 dev_i,
  input  logic [2:0]                       field_i,
  input  logic [CFG_W-1:0]                 wdata_i,
  output logic [NUM_DEV-1:0][IO_AW-1:0]    io_base_o,
  output logic [NUM_DEV-1:0][CODE_W-1:0]   io_size_o,
  output logic [NUM_DEV-1:0]               active_o,
  output logic [NUM_DEV-1:0]               rc_en_o,
  output logic [NUM_DEV-1:0]               rc_pat_o,
  output logic [NUM_MEM-1:0][MEM_FW-1:0]   mem_base_o,
  output logic [NUM_MEM-1:0][MEM_FW-1:0]   mem_top_o,
  output logic                             mode_o,
  output logic [1:0][CODE_W-1:0]           oen_code_o
);
  cfg_field_e fld;
  assign fld = cfg_field_e'(field_i);

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic [IO_AW-1:0]  base_q;
    logic [CODE_W-1:0] size_q;
    logic [2:0]        ctrl_q;
    logic              hit;
    assign hit = we_i && (dev_i == DEV_W'(d));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q <= '0;
        size_q <= '0;
        ctrl_q <= '0;
      end else if (hit) begin
        case (fld)
          FLD_IO_BASE: base_q <= wdata_i[IO_AW-1:0];
          FLD_IO_SIZE: size_q <= wdata_i[CODE_W-1:0];
          FLD_CTRL:    ctrl_q <= wdata_i[2:0];
          default: ;
        endcase
      end
    end
    assign io_base_o[d] = base_q;
    assign io_size_o[d] = size_q;
    assign active_o[d]  = ctrl_q[0];
    assign rc_en_o[d]   = ctrl_q[1];
    assign rc_pat_o[d]  = ctrl_q[2];
  end

  for (genvar m = 0; m < NUM_MEM; m++) begin : g_mem
    logic [MEM_FW-1:0] lo_q, hi_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (we_i && dev_i == DEV_W'(m)) begin
        if (fld == FLD_MEM_BASE) lo_q <= wdata_i[MEM_FW-1:0];
        if (fld == FLD_MEM_TOP)  hi_q <= wdata_i[MEM_FW-1:0];
      end
    end
    assign mem_base_o[m] = lo_q;
    assign mem_top_o[m]  = hi_q;
  end

  logic [2*CODE_W:0] glob_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          glob_q <= '0;
    else if (we_i && fld == FLD_GLOBAL)   glob_q <= wdata_i[2*CODE_W:0];
  end
  assign mode_o        = glob_q[0];
  assign oen_code_o[0] = glob_q[CODE_W:1];
  assign oen_code_o[1] = glob_q[2*CODE_W:CODE_W+1];

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(glob_q)) else $error("global config changed without write"); // R10
endmodule

// File: rtl/pnp_io_match.sv
module pnp_io_match
  import pnp_cs_pkg::*;
#(
  parameter int IO_AW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IO_AW-1:0]  addr_i,
  input  logic [IO_AW-1:0]  base_i,
  input  logic [CODE_W-1:0] size_i,
  input  logic              en_i,
  output logic              hit_o,
  output logic              cs_o
);
  logic [CODE_W-1:0] eff;
  logic [IO_AW-1:0]  keep;
  assign eff   = (size_i > CODE_W'(MAX_SIZE)) ? CODE_W'(MAX_SIZE) : size_i;
  assign keep  = {IO_AW{1'b1}} << eff;
  assign hit_o = ((addr_i ^ base_i) & keep) == '0;
  assign cs_o  = hit_o && en_i;

  AST_CS_UPPER_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_o |-> addr_i[IO_AW-1:MAX_SIZE] == base_i[IO_AW-1:MAX_SIZE]) else $error("upper bits differ"); // R2
endmodule

// File: rtl/pnp_mem_match.sv
module pnp_mem_match #(
  parameter int MEM_AW = 24,
  parameter int MEM_FW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MEM_AW-1:0] addr_i,
  input  logic [MEM_FW-1:0] base_i,
  input  logic [MEM_FW-1:0] top_i,
  input  logic              en_i,
  output logic              cs_o
);
  logic [MEM_FW-1:0] page;
  assign page = addr_i[MEM_AW-1 -: MEM_FW];
  assign cs_o = en_i && (page >= base_i) && (page <= top_i);

  AST_MCS_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_o |-> base_i <= top_i) else $error("select from empty window"); // R5
endmodule

// File: rtl/pnp_cs_decoder.sv
module pnp_cs_decoder
  import pnp_cs_pkg::*;
#(
  parameter int NUM_DEV = 5,
  parameter int NUM_MEM = 2,
  parameter int IO_AW   = 16,
  parameter int MEM_AW  = 24,
  parameter int MEM_GR  = 8,
  localparam int MEM_FW = MEM_AW - MEM_GR,
  localparam int CFG_W  = (IO_AW > MEM_FW) ? IO_AW : MEM_FW,
  localparam int DEV_W  = $clog2(NUM_DEV)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [DEV_W-1:0]   cfg_dev_i,
  input  logic [2:0]         cfg_field_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  input  logic [IO_AW-1:0]   io_addr_i,
  input  logic [MEM_AW-1:0]  mem_addr_i,
  input  logic               aen_i,
  input  logic               ior_i,
  output logic [NUM_DEV-1:0] iocs_o,
  output logic [NUM_MEM-1:0] mcs_o,
  output logic [1:0]         oen_o,
  output logic               rd_oe_o,
  output logic [7:0]         rd_data_o
);
  logic [NUM_DEV-1:0][IO_AW-1:0]  io_base;
  logic [NUM_DEV-1:0][CODE_W-1:0] io_size;
  logic [NUM_DEV-1:0]             active, rc_en, rc_pat, allowed, io_hit, rc_cand;
  logic [NUM_MEM-1:0][MEM_FW-1:0] mem_base, mem_top;
  logic                           mode_q;
  logic [1:0][CODE_W-1:0]         oen_code;

  pnp_cfg_regs #(
    .NUM_DEV(NUM_DEV), .NUM_MEM(NUM_MEM), .IO_AW(IO_AW),
    .MEM_FW(MEM_FW), .CFG_W(CFG_W), .DEV_W(DEV_W)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .dev_i(cfg_dev_i), .field_i(cfg_field_i), .wdata_i(cfg_wdata_i),
    .io_base_o(io_base), .io_size_o(io_size), .active_o(active),
    .rc_en_o(rc_en), .rc_pat_o(rc_pat), .mem_base_o(mem_base), .mem_top_o(mem_top),
    .mode_o(mode_q), .oen_code_o(oen_code)
  );

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_io
    // two-device layout keeps only the memory-capable devices
    assign allowed[d] = mode_q || (d < NUM_MEM);
    pnp_io_match #(.IO_AW(IO_AW)) u_io (
      .clk_i, .rst_ni,
      .addr_i(io_addr_i), .base_i(io_base[d]), .size_i(io_size[d]),
      .en_i(active[d] && allowed[d] && !aen_i),
      .hit_o(io_hit[d]), .cs_o(iocs_o[d])
    );
    assign rc_cand[d] = ior_i && !aen_i && allowed[d] && !active[d] && rc_en[d] && io_hit[d];
  end

  for (genvar m = 0; m < NUM_MEM; m++) begin : g_mem
    pnp_mem_match #(.MEM_AW(MEM_AW), .MEM_FW(MEM_FW)) u_mem (
      .clk_i, .rst_ni,
      .addr_i(mem_addr_i), .base_i(mem_base[m]), .top_i(mem_top[m]),
      .en_i(!mode_q && active[m]), .cs_o(mcs_o[m])
    );
  end

  function automatic logic [NUM_DEV-1:0] oen_pick(logic [CODE_W-1:0] code, logic five);
    logic [NUM_DEV-1:0] v;
    for (int d = 0; d < NUM_DEV; d++) begin
      if (five) v[d] = (code == CODE_W'(d));
      else      v[d] = (d == 0 && (code == 3'd0 || code == 3'd2)) ||
                       (d == 1 && (code == 3'd1 || code == 3'd2));
    end
    return v;
  endfunction

  assign oen_o[0] = ior_i && |(iocs_o & oen_pick(oen_code[0], mode_q));
  assign oen_o[1] = ior_i && mode_q && |(iocs_o & oen_pick(oen_code[1], mode_q));

  always_comb begin
    rd_oe_o   = 1'b0;
    rd_data_o = '0;
    for (int d = NUM_DEV - 1; d >= 0; d--) begin
      if (rc_cand[d]) begin
        rd_oe_o   = 1'b1;
        rd_data_o = rc_pat[d] ? RC_BYTE_SET : RC_BYTE_CLR;
      end
    end
  end

  AST_AEN_NO_IOCS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aen_i |-> iocs_o == '0) else $error("I/O select during AEN"); // R3
  AST_OEN_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|oen_o) |-> (ior_i && !aen_i)) else $error("OEN without read"); // R8
  AST_FIVE_NO_MCS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q |-> mcs_o == '0) else $error("memory select in five-device mode"); // R6
  AST_RC_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_oe_o |-> (ior_i && !aen_i)) else $error("range check drive without read"); // R7
  AST_RC_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_oe_o |-> (rd_data_o == RC_BYTE_SET || rd_data_o == RC_BYTE_CLR)) else $error("bad response byte"); // R7
  AST_INACTIVE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iocs_o & ~active) == '0) else $error("inactive device selected"); // R4
endmodule

// File: tb/pnp_cs_decoder_bench.sv
module pnp_cs_decoder_bench;
  localparam int CLK_P = 20;

  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_dev = 0, cfg_field = 0;
  logic [15:0] cfg_wdata = 0, io_addr = 0;
  logic [23:0] mem_addr = 0;
  logic        aen = 0, ior = 0;
  logic [4:0]  iocs;
  logic [1:0]  mcs, oen;
  logic        rd_oe;
  logic [7:0]  rd_data;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // bench model of configuration
  logic [15:0] m_base [5];
  logic [2:0]  m_size [5];
  logic [2:0]  m_ctrl [5];
  logic [15:0] m_mlo [2];
  logic [15:0] m_mhi [2];
  logic [6:0]  m_glob;

  always #(CLK_P/2) clk = ~clk;

  pnp_cs_decoder u_pnp_cs_decoder (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_dev_i(cfg_dev),
    .cfg_field_i(cfg_field), .cfg_wdata_i(cfg_wdata), .io_addr_i(io_addr),
    .mem_addr_i(mem_addr), .aen_i(aen), .ior_i(ior), .iocs_o(iocs),
    .mcs_o(mcs), .oen_o(oen), .rd_oe_o(rd_oe), .rd_data_o(rd_data)
  );

  function automatic bit in_win(int d);
    int k = (m_size[d] > 6) ? 6 : int'(m_size[d]);
    return (io_addr >> k) == (m_base[d] >> k);
  endfunction

  function automatic bit dev_on(int d);
    return m_glob[0] || d < 2;
  endfunction

  function automatic logic [4:0] e_iocs();
    logic [4:0] v = '0;
    for (int d = 0; d < 5; d++) v[d] = !aen && m_ctrl[d][0] && dev_on(d) && in_win(d);
    return v;
  endfunction

  function automatic logic [1:0] e_mcs();
    logic [1:0] v = '0;
    for (int m = 0; m < 2; m++)
      v[m] = !m_glob[0] && m_ctrl[m][0] && mem_addr[23:8] >= m_mlo[m] && mem_addr[23:8] <= m_mhi[m];
    return v;
  endfunction

  function automatic bit picks(logic [2:0] c, int d);
    if (m_glob[0]) return c == 3'(d);
    return (d == 0 && (c == 0 || c == 2)) || (d == 1 && (c == 1 || c == 2));
  endfunction

  function automatic logic [1:0] e_oen();
    logic [4:0] cs = e_iocs();
    logic [1:0] v = '0;
    for (int d = 0; d < 5; d++) begin
      if (ior && cs[d] && picks(m_glob[3:1], d)) v[0] = 1;
      if (ior && m_glob[0] && cs[d] && picks(m_glob[6:4], d)) v[1] = 1;
    end
    return v;
  endfunction

  function automatic logic [8:0] e_rc();
    for (int d = 0; d < 5; d++)
      if (ior && !aen && dev_on(d) && !m_ctrl[d][0] && m_ctrl[d][1] && in_win(d))
        return {1'b1, m_ctrl[d][2] ? 8'h55 : 8'hAA};
    return 9'h000;
  endfunction

  task automatic chk(string tag, logic [8:0] act, logic [8:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cmp_all(string tag);
    chk({tag, " iocs R2"}, 9'(iocs), 9'(e_iocs()));
    chk({tag, " mcs R5"}, 9'(mcs), 9'(e_mcs()));
    chk({tag, " oen R8"}, 9'(oen), 9'(e_oen()));
    chk({tag, " rc R7"}, {rd_oe, rd_data}, e_rc());
  endtask

  task automatic cfg(int dev, int fld, logic [15:0] data);
    cfg_we = 1; cfg_dev = 3'(dev); cfg_field = 3'(fld); cfg_wdata = data;
    @(posedge clk); #1;
    cfg_we = 0;
    if (fld == 5) m_glob = data[6:0];
    else if (dev < 5) begin
      case (fld)
        0: m_base[dev] = data;
        1: m_size[dev] = data[2:0];
        2: if (dev < 2) m_mlo[dev] = data;
        3: if (dev < 2) m_mhi[dev] = data;
        4: m_ctrl[dev] = data[2:0];
        default: ;
      endcase
    end
  endtask

  task automatic probe(logic [15:0] a, logic [23:0] ma, logic e, logic r, string tag);
    io_addr = a; mem_addr = ma; aen = e; ior = r;
    #(CLK_P/4);
    cmp_all(tag);
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int d = 0; d < 5; d++) begin m_base[d] = 0; m_size[d] = 0; m_ctrl[d] = 0; end
    for (int m = 0; m < 2; m++) begin m_mlo[m] = 0; m_mhi[m] = 0; end
    m_glob = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    // R1 reset state
    chk("R1 iocs", 9'(iocs), 9'h0);
    chk("R1 mcs", 9'(mcs), 9'h0);
    chk("R1 rc", {rd_oe, rd_data}, 9'h0);
    chk("R1 oen", 9'(oen), 9'h0);

    // R2 size boundaries, five-device mode, dev0 active
    cfg(0, 5, 16'h0001);
    cfg(0, 0, 16'h1238); cfg(0, 1, 16'd3); cfg(0, 4, 16'h1);
    probe(16'h123F, 0, 0, 1, "R2 top edge");
    probe(16'h1240, 0, 0, 1, "R2 above");
    probe(16'h1237, 0, 0, 1, "R2 below");
    cfg(0, 1, 16'd7); cfg(0, 0, 16'h0300);
    probe(16'h033F, 0, 0, 1, "R2 code7 as 64");
    probe(16'h0340, 0, 0, 1, "R2 code7 above");
    // R3 AEN blocks
    probe(16'h0300, 0, 1, 1, "R3 aen");
    chk("R3 iocs under aen", 9'(iocs), 9'h0);
    // R4 inactive
    cfg(0, 4, 16'h0);
    probe(16'h0300, 0, 0, 1, "R4 inactive");
    // R7 range check, dev3 and dev1 overlap, dev1 wins
    cfg(3, 0, 16'h0400); cfg(3, 4, 16'h2);
    cfg(1, 0, 16'h0400); cfg(1, 4, 16'h6);
    probe(16'h0400, 0, 0, 1, "R7 priority");
    chk("R7 byte 55", {rd_oe, rd_data}, 9'h155);
    cfg(1, 4, 16'h0);
    probe(16'h0400, 0, 0, 1, "R7 byte AA");
    chk("R7 byte AA direct", {rd_oe, rd_data}, 9'h1AA);
    // R9 five-device oen1 to dev3
    cfg(3, 4, 16'h1); cfg(0, 5, 16'h0031);
    probe(16'h0400, 0, 0, 1, "R9 oen1 dev3");
    chk("R9 oen direct", 9'(oen), 9'h2);
    // R6 two-device: dev3 silent, mem active
    cfg(0, 5, 16'h0004);
    probe(16'h0400, 0, 0, 1, "R6 dev3 off");
    // R5 memory inclusive edges
    cfg(0, 2, 16'h0C00); cfg(0, 3, 16'h0C0F); cfg(0, 4, 16'h1);
    probe(0, 24'h0C0FFF, 0, 0, "R5 top");
    chk("R5 top direct", 9'(mcs), 9'h1);
    probe(0, 24'h0C1000, 0, 0, "R5 above");
    probe(0, 24'h0BFFFF, 0, 0, "R5 below");
    probe(0, 24'h0C0000, 0, 0, "R5 base");
    // R8 code 010 either device
    cfg(1, 0, 16'h0500); cfg(1, 4, 16'h1);
    probe(16'h0500, 0, 0, 1, "R8 either");
    chk("R8 oen0 either", 9'(oen), 9'h1);
    // R10 ignored writes
    cfg(6, 0, 16'h0000); cfg(1, 6, 16'hFFFF);
    probe(16'h0500, 0, 0, 1, "R10 ignored");
    cfg(1, 0, 16'h0600);
    probe(16'h0600, 0, 0, 0, "R10 next cycle");

    // random phase
    for (int it = 0; it < 3000; it++) begin
      if ($urandom_range(0, 2) == 0) begin
        int dv = $urandom_range(0, 7);
        int fl = $urandom_range(0, 7);
        logic [15:0] dat = 16'($urandom);
        if (fl == 4) dat = {13'h0, 3'($urandom_range(0, 7))};
        if (fl == 2 || fl == 3) dat = {8'h0C, 4'h0, 4'($urandom)};
        cfg(dv, fl, dat);
      end
      begin
        int tgt = $urandom_range(0, 4);
        logic [15:0] a = ($urandom_range(0, 3) == 0) ? 16'($urandom)
                        : m_base[tgt] ^ 16'($urandom_range(0, 127));
        logic [23:0] ma = {8'h0C, 4'h0, 4'($urandom), 8'($urandom)};
        probe(a, ma, $urandom_range(0, 7) == 0, 1'($urandom), "R2/R4/R6/R9 rand");
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule